// File: doc/BRIEF.md
# Commit-Acknowledged Write Port

This block sits in front of a memory controller. It takes writes from a system bus master through a slave port and takes requests from a second, competing requester, and a fixed-priority arbiter chooses between them. A chosen request moves into a single forwarding register, which drives a valid/ready interface toward the downstream memory controller.

A write taken from the bus master is not acknowledged when it is captured. The port presents it to the arbiter and keeps it there until the arbiter accepts it. Only then does the port send a one-cycle response pulse that carries the write's transaction ID. A master that waits for this response, for example to complete a barrier, therefore knows that its data has already entered the memory path. This closes the window in which a later read or write from another agent could overtake a write still held in the port.

The port holds one outstanding write at a time. Back-to-back writes from the same master are ordered by this alone and need no other handling.

Top module: `wr_commit_port`

## Requirements
- R1: After a write is captured (`bw_valid_i` and `bw_ready_o` both high at a clock edge), `bw_ready_o` stays low until the cycle after the response pulse for that write.
- R2: A request accepted by the arbiter appears on `mem_valid_o`, with address, byte enables and data unchanged, in the cycle after acceptance.
- R3: `rsp_valid_o` is raised only in the cycle after the arbiter accepts the captured bus write. It carries that write's `bw_id_i` on `rsp_id_o`.
- R4: `rsp_valid_o` is a single-cycle pulse.
- R5: When the captured bus write and `alt_req_i` request in the same cycle and the forwarding register can load, the second requester wins (`alt_fin_o` high). The bus write waits.
- R6: While the captured bus write is waiting, its request and its address, data and byte enables stay stable.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, the forwarding register holds its contents.
- R8: A response is never issued before its write is on the downstream interface: whenever `rsp_valid_o` is high, `mem_valid_o` is high.
- R9: The arbiter accepts a request only when the forwarding register is empty or being drained. At most one requester is accepted per cycle.
- R10: After reset, `bw_ready_o` is high and `rsp_valid_o`, `mem_valid_o` and `alt_fin_o` are low.
- R11: Once the response for a write has been seen, a read of memory at that address returns the written bytes, merged according to the byte enables (bit i of the enable selects byte i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bw_valid_i | input | 1 | Bus master offers a write |
| bw_ready_o | output | 1 | Port can capture a write |
| bw_addr_i | input | ADDR_W | Write address |
| bw_data_i | input | DATA_W | Write data |
| bw_be_i | input | DATA_W/8 | Byte enables |
| bw_id_i | input | ID_W | Transaction ID |
| rsp_valid_o | output | 1 | Write response pulse |
| rsp_id_o | output | ID_W | ID of the responded write |
| alt_req_i | input | 1 | Second requester request, held until accepted |
| alt_addr_i | input | ADDR_W | Second requester address |
| alt_data_i | input | DATA_W | Second requester data |
| alt_be_i | input | DATA_W/8 | Second requester byte enables |
| alt_fin_o | output | 1 | Accept pulse to second requester |
| mem_valid_o | output | 1 | Downstream request valid |
| mem_ready_i | input | 1 | Downstream ready |
| mem_addr_o | output | ADDR_W | Downstream address |
| mem_data_o | output | DATA_W | Downstream data |
| mem_be_o | output | DATA_W/8 | Downstream byte enables |

## Verification
Arbitration and the response can fall into the same cycle, and both depend on the forwarding slot being free. The bench first stalls the downstream side, so that one write from the second requester fills the forwarding register. It then raises a bus write and a second request from the other requester together, and releases the stall. It judges that the second requester is accepted first and that no response appears while the bus write is still waiting. It then checks that the response arrives in the same cycle the bus write reaches the downstream interface, and that memory holds all three writes in arbitration order.

// File: rtl/wcp_pkg.sv
package wcp_pkg;
  localparam int unsigned NUM_REQ = 2;
  // requester slots; higher index wins
  localparam int unsigned REQ_BUS = 0;
  localparam int unsigned REQ_ALT = 1;
endpackage

// File: rtl/wcp_slave.sv
module wcp_slave #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PW    = ADDR_W + BE_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              req_o,
  output logic [PW-1:0]     pay_o,
  input  logic              fin_i,
  output logic              rsp_valid_o,
  output logic [ID_W-1:0]   rsp_id_o
);
  logic            pend_q, rsp_q;
  logic [PW-1:0]   pay_q;
  logic [ID_W-1:0] id_q;

  assign ready_o     = !pend_q && !rsp_q;
  assign req_o       = pend_q;
  assign pay_o       = pay_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_id_o    = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rsp_q  <= 1'b0;
      pay_q  <= '0;
      id_q   <= '0;
    end else begin
      rsp_q <= pend_q && fin_i;  // ack only once committed
      if (valid_i && ready_o) begin
        pend_q <= 1'b1;
        pay_q  <= {addr_i, be_i, data_i};
        id_q   <= id_i;
      end else if (fin_i) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wcp_arb.sv
module wcp_arb #(
  parameter int unsigned N = 2
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (en_i && req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wcp_fwd.sv
module wcp_fwd #(
  parameter int unsigned PW = 52
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] pay_i,
  output logic          free_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [PW-1:0] pay_o
);
  logic          valid_q;
  logic [PW-1:0] pay_q;

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign pay_o   = pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pay_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      pay_q   <= pay_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wr_commit_port.sv
module wr_commit_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bw_valid_i,
  output logic              bw_ready_o,
  input  logic [ADDR_W-1:0] bw_addr_i,
  input  logic [DATA_W-1:0] bw_data_i,
  input  logic [BE_W-1:0]   bw_be_i,
  input  logic [ID_W-1:0]   bw_id_i,
  output logic              rsp_valid_o,
  output logic [ID_W-1:0]   rsp_id_o,
  input  logic              alt_req_i,
  input  logic [ADDR_W-1:0] alt_addr_i,
  input  logic [DATA_W-1:0] alt_data_i,
  input  logic [BE_W-1:0]   alt_be_i,
  output logic              alt_fin_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [BE_W-1:0]   mem_be_o
);
  import wcp_pkg::*;
  localparam int unsigned PW = ADDR_W + BE_W + DATA_W;

  logic               bus_req, bus_fin, slot_free;
  logic [PW-1:0]      bus_payload, win_payload, fwd_payload;
  logic [NUM_REQ-1:0] req, gnt;

  wcp_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_slave (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(bw_valid_i), .ready_o(bw_ready_o),
    .addr_i(bw_addr_i), .data_i(bw_data_i), .be_i(bw_be_i), .id_i(bw_id_i),
    .req_o(bus_req), .pay_o(bus_payload), .fin_i(bus_fin),
    .rsp_valid_o(rsp_valid_o), .rsp_id_o(rsp_id_o)
  );

  always_comb begin
    req          = '0;
    req[REQ_BUS] = bus_req;
    req[REQ_ALT] = alt_req_i;
  end

  wcp_arb #(.N(NUM_REQ)) u_arb (.en_i(slot_free), .req_i(req), .gnt_o(gnt));

  assign bus_fin     = gnt[REQ_BUS];
  assign alt_fin_o   = gnt[REQ_ALT];
  assign win_payload = gnt[REQ_ALT] ? {alt_addr_i, alt_be_i, alt_data_i} : bus_payload;

  wcp_fwd #(.PW(PW)) u_fwd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(|gnt), .pay_i(win_payload), .free_o(slot_free),
    .valid_o(mem_valid_o), .ready_i(mem_ready_i), .pay_o(fwd_payload)
  );

  assign {mem_addr_o, mem_be_o, mem_data_o} = fwd_payload;
endmodule

// File: rtl/wcp_checker.sv
module wcp_checker #(
  parameter int unsigned PW = 52
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bw_valid_i,
  input logic          bw_ready_o,
  input logic          rsp_valid_o,
  input logic          alt_req_i,
  input logic          alt_fin_o,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [PW-1:0] mem_payload,
  input logic          bus_req,
  input logic          bus_fin,
  input logic [PW-1:0] bus_payload
);
  p_ready_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_valid_i && bw_ready_o |=> !bw_ready_o);
  p_fwd_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_fin |=> mem_valid_o && mem_payload == $past(bus_payload));
  p_rsp_after_fin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(bus_fin));
  p_rsp_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  p_alt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_req_i && bus_req && (!mem_valid_o || mem_ready_i) |-> alt_fin_o && !bus_fin);
  p_bus_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req && !bus_fin |=> bus_req && $stable(bus_payload));
  p_fwd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_payload));
  p_rsp_on_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> mem_valid_o);
  p_slot_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_fin_o || bus_fin |-> !mem_valid_o || mem_ready_i);
  p_one_fin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({alt_fin_o, bus_fin}));
endmodule

bind wr_commit_port wcp_checker #(.PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .bw_valid_i(bw_valid_i), .bw_ready_o(bw_ready_o),
  .rsp_valid_o(rsp_valid_o), .alt_req_i(alt_req_i), .alt_fin_o(alt_fin_o),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_payload({mem_addr_o, mem_be_o, mem_data_o}),
  .bus_req(bus_req), .bus_fin(bus_fin), .bus_payload(bus_payload)
);

// File: tb/wr_commit_port_test.sv
`timescale 1ns/1ps
module wr_commit_port_test;
  localparam int unsigned AW = 16, DW = 32, IW = 4, BW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          bw_valid = 0, bw_ready, rsp_valid, alt_req = 0, alt_fin;
  logic [AW-1:0] bw_addr = 0, alt_addr = 0, mem_addr;
  logic [DW-1:0] bw_data = 0, alt_data = 0, mem_data;
  logic [BW-1:0] bw_be = 0, alt_be = 0, mem_be;
  logic [IW-1:0] bw_id = 0, rsp_id;
  logic          mem_valid, mem_ready = 1;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [16];

  wr_commit_port #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bw_valid_i(bw_valid), .bw_ready_o(bw_ready),
    .bw_addr_i(bw_addr), .bw_data_i(bw_data), .bw_be_i(bw_be), .bw_id_i(bw_id),
    .rsp_valid_o(rsp_valid), .rsp_id_o(rsp_id),
    .alt_req_i(alt_req), .alt_addr_i(alt_addr), .alt_data_i(alt_data), .alt_be_i(alt_be),
    .alt_fin_o(alt_fin),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_be_o(mem_be)
  );

  // memory behind the downstream interface
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready)
      for (int b = 0; b < BW; b++)
        if (mem_be[b]) model[mem_addr[3:0]][8*b +: 8] <= mem_data[8*b +: 8];
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_bus(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [BW-1:0] be, input logic [IW-1:0] id);
    bw_valid = 1; bw_addr = a; bw_data = d; bw_be = be; bw_id = id;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(bw_ready == 1, "R10 ready", bw_ready, 1);
    check(rsp_valid == 0 && mem_valid == 0 && alt_fin == 0, "R10 idle",
          {rsp_valid, mem_valid, alt_fin}, 0);
  endtask

  task automatic t_single;
    put_bus(16'h3, 32'hA1B2C3D4, 4'hF, 4'h5);
    @(negedge clk);
    bw_valid = 0;
    check(bw_ready == 0, "R1 ready low after capture", bw_ready, 0);
    check(rsp_valid == 0, "R8 no early response", rsp_valid, 0);
    check(mem_valid == 0, "R2 not yet forwarded", mem_valid, 0);
    @(negedge clk);
    check(mem_valid == 1 && mem_addr == 16'h3 && mem_data == 32'hA1B2C3D4 && mem_be == 4'hF,
          "R2 forwarded", {mem_valid, mem_addr, mem_data}, {1'b1, 16'h3, 32'hA1B2C3D4});
    check(rsp_valid == 1 && rsp_id == 4'h5, "R3 response id", {rsp_valid, rsp_id}, {1'b1, 4'h5});
    check(bw_ready == 0, "R1 ready low during response", bw_ready, 0);
    @(negedge clk);
    check(rsp_valid == 0, "R4 single pulse", rsp_valid, 0);
    check(bw_ready == 1, "R1 ready back", bw_ready, 1);
    check(model[3] == 32'hA1B2C3D4, "R11 read after response", model[3], 32'hA1B2C3D4);
  endtask

  task automatic t_collide;
    mem_ready = 0;
    alt_req = 1; alt_addr = 16'h4; alt_data = 32'h11111111; alt_be = 4'hF;
    #1 check(alt_fin == 1, "R9 alt accepted into empty slot", alt_fin, 1);
    @(negedge clk);
    alt_req = 0;
    put_bus(16'h6, 32'h66666666, 4'hF, 4'h9);
    @(negedge clk);
    bw_valid = 0;
    alt_req = 1; alt_addr = 16'h5; alt_data = 32'h22222222; alt_be = 4'hF;
    #1 check(alt_fin == 0, "R9 no accept while slot full", alt_fin, 0);
    check(mem_valid == 1 && mem_data == 32'h11111111, "R7 hold under stall", mem_data, 32'h11111111);
    @(negedge clk);
    check(mem_data == 32'h11111111 && rsp_valid == 0, "R7 still held", mem_data, 32'h11111111);
    mem_ready = 1;
    #1 check(alt_fin == 1, "R5 second requester wins", alt_fin, 1);
    @(negedge clk);
    alt_req = 0;
    check(mem_data == 32'h22222222 && mem_addr == 16'h5, "R5 alt forwarded first", mem_data, 32'h22222222);
    check(rsp_valid == 0, "R8 bus write waited, no response", rsp_valid, 0);
    @(negedge clk);
    check(rsp_valid == 1 && rsp_id == 4'h9, "R3 response after win", {rsp_valid, rsp_id}, {1'b1, 4'h9});
    check(mem_valid == 1 && mem_data == 32'h66666666, "R8 write on downstream with response",
          mem_data, 32'h66666666);
    @(negedge clk);
    check(model[4] == 32'h11111111 && model[5] == 32'h22222222 && model[6] == 32'h66666666,
          "R11 all three in memory", model[6], 32'h66666666);
  endtask

  task automatic t_stalled_pair;
    mem_ready = 0;
    put_bus(16'h8, 32'h0000ABCD, 4'hF, 4'h1);
    @(negedge clk);
    bw_valid = 0;
    @(negedge clk);
    check(rsp_valid == 1 && mem_valid == 1, "R8 response with empty slot despite stall",
          {rsp_valid, mem_valid}, 2'b11);
    @(negedge clk);
    check(bw_ready == 1, "R1 ready after response", bw_ready, 1);
    put_bus(16'h9, 32'h12345678, 4'b0101, 4'h2);
    @(negedge clk);
    bw_valid = 0;
    check(rsp_valid == 0 && mem_data == 32'h0000ABCD, "R7 second write blocked", mem_data, 32'h0000ABCD);
    @(negedge clk);
    check(rsp_valid == 0, "R8 no response while blocked", rsp_valid, 0);
    mem_ready = 1;
    @(negedge clk);
    check(rsp_valid == 1 && rsp_id == 4'h2 && mem_be == 4'b0101, "R2 byte enables forwarded",
          {rsp_id, mem_be}, {4'h2, 4'b0101});
    @(negedge clk);
    check(model[8] == 32'h0000ABCD, "R11 first write", model[8], 32'h0000ABCD);
    check(model[9] == 32'hEE34EE78, "R11 byte merge", model[9], 32'hEE34EE78);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 32'hEEEEEEEE;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_single();
    t_collide();
    t_stalled_pair();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule